// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block switches a set of independently powered domains on and off, one at a time. A request names a domain by its control-bit position and says whether the domain should go off or on. The block keeps a power-down control word with one bit per domain, and a read-only status word that reports the actual power state of each domain. Each accepted change runs a fixed sequence:

1. Force the domain's clocks open.
2. For a power-off, quiesce the domain's bus port, or hold a secondary core in reset.
3. Flip the control bit.
4. Wait for the power switch to settle and for the status to confirm.
5. For a power-on, release the bus port or the core reset.
6. Let the clock gates return to their own settings.

The power switches are modelled inside the block as delayed status feedback. The delay comes from two programmable settle counts, one for each direction.

Requests arrive on a valid/ready channel. The block raises `req_ready` only while no sequence is running. A requester that sees `req_ready` low must hold `req_valid`, `req_bit` and `req_off` steady until a clock edge where both are high. A request is accepted on such an edge, even when it turns out to be a no-op. The control and status words, `busy`, the settle counts and the per-domain bus-idle and core-reset pins are plain level signals.

Top module: `pds_top`

## Requirements
- R1: After reset, `pwr_ctl`, `pwr_stat`, `idle_req`, `core_rst` and `clk_force` are all zero, `busy` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a sequence runs. A request held during that time is accepted once the sequence ends, and is then carried out.
- R3: Domains occupy control bits 0–3 (cores 0–3), 5 (system bus), 6 (peripherals), 7 (video output), 8 (video codec), 9 (graphics), 11 (snoop unit) and 14 (HEVC). In `pwr_ctl` a bit at 1 requests power-off and a bit at 0 requests power-on. In `pwr_stat` a bit at 0 means powered on and a bit at 1 means powered off. When idle, every status bit agrees with its control bit.
- R4: The HEVC domain is controlled through control bit 14 but reports its state on status bit 10. Status bit 14 stays 0.
- R5: A request for the state that the domain's status bit already shows is accepted and has no effect: `busy` stays 0 and no output changes.
- R6: Requests naming control positions 4, 10, 12, 13 or 15 are accepted and ignored. Those bits of `pwr_ctl` stay 0.
- R7: For a domain with no bus handshake and no core reset, the status bit changes exactly N+3 clock edges after the accepting edge. N is `settle_dn` for a power-off and `settle_up` for a power-on. The count is reloaded for every transition.
- R8: For the peripheral, video output, video codec, graphics and HEVC domains, a power-off raises `idle_req` at the domain's control position. The control bit changes only after `idle_ack` at that position is 1, and `idle_req` stays high while the domain is off. A power-on drops `idle_req` only after the status confirms power-on, and the sequence then waits for `idle_ack` to fall.
- R9: For cores 1–3, a power-off asserts `core_rst` at the core's index before the control bit changes. That reset is released only after the status confirms power-on. Core 0 never receives a reset.
- R10: For the video output, video codec, graphics and HEVC domains, `clk_force` is one-hot at the domain's control position for the whole time `busy` is 1. At every other time `clk_force` is zero.
- R11: `busy` is 1 from the edge after a non-trivial acceptance until the sequence ends. `pwr_stat` changes only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted (no sequence running) |
| req_bit | input | 4 | Control-bit position of the target domain |
| req_off | input | 1 | 1 = power off, 0 = power on |
| settle_up | input | CNT_W | Settle count for power-on |
| settle_dn | input | CNT_W | Settle count for power-off |
| idle_ack | input | 16 | Bus-idle acknowledge per control position |
| idle_req | output | 16 | Bus-idle request per control position |
| clk_force | output | 16 | Clock-gate override per control position |
| core_rst | output | 4 | Soft reset per core index |
| pwr_ctl | output | 16 | Power-down control word |
| pwr_stat | output | 16 | Power status word (1 = off) |
| busy | output | 1 | A sequence is running |

## Verification
The bench builds the block with its default parameters: a 16-bit settle counter and the fixed 16-position domain map. It drives the settle counts at run time with small values, including 0. This makes the exact N+3 settle timing and the per-transition reload of the counter measurable within a few cycles. A bench-side bus model acknowledges idle requests two cycles late, so both waiting steps of the handshake are exercised. The bench also runs a held second request behind a running one, the HEVC bit remap, a no-op request and the unused positions.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int CTL_W = 16;
  localparam int IDX_W = $clog2(CTL_W);
  localparam int NCPU  = 4;

  localparam logic [CTL_W-1:0] VALID_MASK   = 16'h4BEF;
  localparam logic [CTL_W-1:0] NIU_MASK     = 16'h43C0;
  localparam logic [CTL_W-1:0] CLK_MASK     = 16'h4380;
  localparam logic [CTL_W-1:0] SEC_CPU_MASK = 16'h000E;

  localparam logic [IDX_W-1:0] HEVC_CTL  = 4'd14;
  localparam logic [IDX_W-1:0] HEVC_STAT = 4'd10;

  typedef enum logic [3:0] {
    S_IDLE, S_UNGATE, S_QREQ, S_HOLDRST, S_SWITCH,
    S_SETTLE, S_QREL, S_RELRST, S_REGATE
  } seq_state_e;

  function automatic logic [IDX_W-1:0] stat_idx(input logic [IDX_W-1:0] c);
    return (c == HEVC_CTL) ? HEVC_STAT : c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_to_stat(input logic [CTL_W-1:0] c);
    logic [CTL_W-1:0] r;
    r = c & ~(CTL_W'(1) << HEVC_CTL);
    r[HEVC_STAT] = c[HEVC_CTL];
    return r;
  endfunction
endpackage

// File: rtl/pds_switch_model.sv
module pds_switch_model
  import pds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_sidx,
  input  logic             load_off,
  input  logic [CNT_W-1:0] settle_up,
  input  logic [CNT_W-1:0] settle_dn,
  output logic [CTL_W-1:0] pwr_stat
);
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [IDX_W-1:0] tgt_idx;
  logic             tgt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      run      <= 1'b0;
      tgt_idx  <= '0;
      tgt_val  <= 1'b0;
      pwr_stat <= '0;
    end else if (load) begin
      cnt     <= load_off ? settle_dn : settle_up;
      run     <= 1'b1;
      tgt_idx <= load_sidx;
      tgt_val <= load_off;
    end else if (run) begin
      if (cnt == '0) begin
        pwr_stat[tgt_idx] <= tgt_val;
        run               <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pds_gate_force.sv
module pds_gate_force
  import pds_pkg::*;
(
  input  logic             busy,
  input  logic [IDX_W-1:0] act_bit,
  output logic [CTL_W-1:0] clk_force
);
  for (genvar i = 0; i < CTL_W; i++) begin : g_force
    if (CLK_MASK[i]) begin : g_on
      assign clk_force[i] = busy && (act_bit == IDX_W'(i));
    end else begin : g_off
      assign clk_force[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pds_seq.sv
module pds_seq
  import pds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_bit,
  input  logic             req_off,
  output logic             req_ready,
  input  logic [CTL_W-1:0] pwr_stat,
  input  logic [CTL_W-1:0] idle_ack,
  output logic [CTL_W-1:0] idle_req,
  output logic [NCPU-1:0]  core_rst,
  output logic [CTL_W-1:0] pwr_ctl,
  output logic             busy,
  output logic [IDX_W-1:0] act_bit,
  output logic             act_off,
  output logic             sw_load
);
  seq_state_e       state;
  logic [IDX_W-1:0] act_sidx;
  logic             act_niu, act_cpu, stat_done;

  assign act_sidx  = stat_idx(act_bit);
  assign act_niu   = NIU_MASK[act_bit];
  assign act_cpu   = SEC_CPU_MASK[act_bit];
  assign stat_done = (pwr_stat[act_sidx] == act_off);
  assign busy      = (state != S_IDLE);
  assign req_ready = (state == S_IDLE);
  assign sw_load   = (state == S_SWITCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      act_bit  <= '0;
      act_off  <= 1'b0;
      idle_req <= '0;
      core_rst <= '0;
      pwr_ctl  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            act_bit <= req_bit;
            act_off <= req_off;
            if (VALID_MASK[req_bit] && (pwr_stat[stat_idx(req_bit)] != req_off))
              state <= S_UNGATE;
          end
        end
        S_UNGATE: begin
          if (act_off && act_niu) begin
            idle_req[act_bit] <= 1'b1;
            state             <= S_QREQ;
          end else if (act_off && act_cpu) begin
            core_rst[act_bit[1:0]] <= 1'b1;
            state                  <= S_HOLDRST;
          end else begin
            state <= S_SWITCH;
          end
        end
        S_QREQ:    if (idle_ack[act_bit]) state <= S_SWITCH;
        S_HOLDRST: state <= S_SWITCH;
        S_SWITCH: begin
          pwr_ctl[act_bit] <= act_off;
          state            <= S_SETTLE;
        end
        S_SETTLE: begin
          if (stat_done) begin
            if (!act_off && act_niu) begin
              idle_req[act_bit] <= 1'b0;
              state             <= S_QREL;
            end else if (!act_off && act_cpu) begin
              core_rst[act_bit[1:0]] <= 1'b0;
              state                  <= S_RELRST;
            end else begin
              state <= S_REGATE;
            end
          end
        end
        S_QREL:   if (!idle_ack[act_bit]) state <= S_REGATE;
        S_RELRST: state <= S_REGATE;
        S_REGATE: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pds_top.sv
module pds_top
  import pds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_bit,
  input  logic             req_off,
  input  logic [CNT_W-1:0] settle_up,
  input  logic [CNT_W-1:0] settle_dn,
  input  logic [15:0]      idle_ack,
  output logic [15:0]      idle_req,
  output logic [15:0]      clk_force,
  output logic [3:0]       core_rst,
  output logic [15:0]      pwr_ctl,
  output logic [15:0]      pwr_stat,
  output logic             busy
);
  logic [IDX_W-1:0] act_bit;
  logic             act_off, sw_load;

  pds_seq u_seq (
    .clk, .rst_n, .req_valid, .req_bit, .req_off, .req_ready,
    .pwr_stat, .idle_ack, .idle_req, .core_rst, .pwr_ctl, .busy,
    .act_bit, .act_off, .sw_load
  );

  pds_switch_model #(.CNT_W(CNT_W)) u_sw (
    .clk, .rst_n, .load(sw_load), .load_sidx(stat_idx(act_bit)),
    .load_off(act_off), .settle_up, .settle_dn, .pwr_stat
  );

  pds_gate_force u_force (.busy, .act_bit, .clk_force);
endmodule

// File: rtl/pds_checker.sv
module pds_checker
  import pds_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [15:0] pwr_ctl,
  input logic [15:0] pwr_stat,
  input logic [15:0] idle_req,
  input logic [15:0] idle_ack,
  input logic [3:0]  core_rst,
  input logic [15:0] clk_force
);
  a_r11_stat_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_stat != $past(pwr_stat)) |-> $past(busy));

  a_r3_idle_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pwr_stat == ctl_to_stat(pwr_ctl)));

  a_r8_quiesce_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_ctl & ~$past(pwr_ctl) & NIU_MASK & ~(idle_req & idle_ack)) == '0));

  a_r9_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_ctl[3:0] & ~$past(pwr_ctl[3:0]) & SEC_CPU_MASK[3:0] & ~core_rst) == '0));

  a_r10_force_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_force) && (busy || (clk_force == '0)));

  a_r6_unused_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_ctl & ~VALID_MASK) == '0));
endmodule

bind pds_top pds_checker u_chk (
  .clk, .rst_n, .busy, .pwr_ctl, .pwr_stat, .idle_req, .idle_ack, .core_rst, .clk_force
);

// File: tb/tb_pds_top.sv
module tb_pds_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_off = 0, busy;
  logic [3:0] req_bit = 0, core_rst;
  logic [CNT_W-1:0] settle_up = 2, settle_dn = 3;
  logic [15:0] idle_ack = 0, ack_d1 = 0, idle_req, clk_force, pwr_ctl, pwr_stat;

  int checks = 0, fails = 0;

  typedef struct { logic [15:0] ctl, stat, idle; logic [3:0] rst; } exp_t;
  exp_t exp_q[$];
  exp_t m;
  event done_ev;

  logic [15:0] watch_force = 0;
  logic        watch_on = 0;
  int          force_bad = 0, order8_bad = 0, order9_bad = 0;
  logic [15:0] prev_ctl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pds_top #(.CNT_W(CNT_W)) dut (.*);

  // bus fabric model: acknowledge two cycles after request
  always @(posedge clk) begin
    ack_d1   <= idle_req;
    idle_ack <= ack_d1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // side monitors (R8, R9, R10)
  always @(negedge clk) if (rst_n) begin
    if (watch_on && busy && clk_force != watch_force) force_bad++;
    if (!busy && clk_force != 0) force_bad++;
    if ((pwr_ctl & ~prev_ctl & 16'h43C0 & ~idle_ack) != 0) order8_bad++;
    if ((pwr_ctl[3:0] & ~prev_ctl[3:0] & 4'hE & ~core_rst) != 0) order9_bad++;
    prev_ctl = pwr_ctl;
  end

  // scoreboard monitor
  initial forever begin
    exp_t e;
    @(done_ev);
    e = exp_q.pop_front();
    check(pwr_ctl == e.ctl, "R3", "pwr_ctl", pwr_ctl, e.ctl);
    check(pwr_stat == e.stat, "R3/R4", "pwr_stat", pwr_stat, e.stat);
    check(idle_req == e.idle, "R8", "idle_req", idle_req, e.idle);
    check(core_rst == e.rst, "R9", "core_rst", core_rst, e.rst);
  end

  function automatic logic [3:0] sidx(input logic [3:0] b);
    return (b == 4'd14) ? 4'd10 : b;
  endfunction

  function automatic void model(input logic [3:0] b, input logic off);
    logic [15:0] valid = 16'h4BEF;
    if (valid[b] && m.stat[sidx(b)] != off) begin
      m.ctl[b] = off;
      m.stat[sidx(b)] = off;
      if (b inside {6, 7, 8, 9, 14}) m.idle[b] = off;
      if (b inside {1, 2, 3}) m.rst[b[1:0]] = off;
    end
  endfunction

  task automatic drive(input logic [3:0] b, input logic off);
    @(negedge clk);
    req_valid = 1; req_bit = b; req_off = off;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic publish();
    exp_q.push_back(m);
    -> done_ev;
    #1;
  endtask

  task automatic do_req(input logic [3:0] b, input logic off);
    model(b, off);
    drive(b, off);
    wait_idle();
    publish();
  endtask

  // R7: measure edges from acceptance to status change on the bus domain
  task automatic timed(input logic off, input int n, input int expect_k);
    int k = 0;
    if (off) settle_dn = CNT_W'(n); else settle_up = CNT_W'(n);
    model(4'd5, off);
    @(negedge clk);
    req_valid = 1; req_bit = 4'd5; req_off = off;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (pwr_stat[5] != off && k < 200) begin
      @(posedge clk); k++;
      @(negedge clk);
    end
    check(k == expect_k, "R7", "settle edges", k, expect_k);
    wait_idle();
    publish();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m = '{ctl: 16'h0, stat: 16'h0, idle: 16'h0, rst: 4'h0};
    repeat (3) @(negedge clk);
    check(pwr_ctl == 0 && pwr_stat == 0, "R1", "ctl/stat", {pwr_ctl, pwr_stat}, 0);
    check(idle_req == 0 && core_rst == 0 && clk_force == 0, "R1", "idle/rst/force",
          {idle_req, core_rst}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && req_ready == 1, "R1", "busy/ready", {busy, req_ready}, 1);

    timed(1, 5, 8);   // R7 off, N=5
    timed(0, 0, 3);   // R7 on, N=0
    timed(1, 2, 5);   // R7 reload, N=2

    // R10: graphics off with forced clocks, R8 handshake
    watch_force = 16'h0200; watch_on = 1;
    do_req(4'd9, 1);
    check(idle_req[9] == 1, "R8", "idle held while off", idle_req[9], 1);
    do_req(4'd9, 0);
    watch_on = 0;
    check(force_bad == 0, "R10", "clk_force violations", force_bad, 0);

    // R4: HEVC
    do_req(4'd14, 1);
    check(pwr_stat[10] == 1 && pwr_stat[14] == 0, "R4", "hevc status", pwr_stat, 16'h0400);

    // R9: secondary core 2 and core 0
    do_req(4'd2, 1);
    check(core_rst[2] == 1, "R9", "core2 reset held", core_rst, 4'h4);
    do_req(4'd0, 1);
    check(core_rst[0] == 0, "R9", "core0 no reset", core_rst, 4'h4);
    do_req(4'd2, 0);
    do_req(4'd0, 0);

    // R5: no-op (domain already off / already on)
    model(4'd14, 1);
    drive(4'd14, 1);
    check(busy == 0, "R5", "busy on noop", busy, 0);
    wait_idle(); publish();
    model(4'd8, 0);
    drive(4'd8, 0);
    check(busy == 0, "R5", "busy on noop on", busy, 0);
    wait_idle(); publish();

    // R6: unused positions
    foreach (m.rst[i]) ;
    for (int p = 10; p <= 15; p++) begin
      if (p == 11 || p == 14) continue;
      model(4'(p), 1);
      drive(4'(p), 1);
      wait_idle(); publish();
    end
    model(4'd4, 1); drive(4'd4, 1); wait_idle(); publish();
    check((pwr_ctl & 16'hB410) == 0, "R6", "unused ctl bits", pwr_ctl, 0);

    // R2: held request behind a running one
    model(4'd7, 1);
    model(4'd6, 1);
    drive(4'd7, 1);
    @(negedge clk);
    req_valid = 1; req_bit = 4'd6; req_off = 1;
    check(req_ready == 0, "R2", "ready while busy", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, "R2", "held request runs", busy, 1);
    wait_idle(); publish();

    check(order8_bad == 0, "R8", "ctl before ack", order8_bad, 0);
    check(order9_bad == 0, "R9", "ctl before reset", order9_bad, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule